// File: doc/BRIEF.md
# Temperature Event Alarm Controller

This block watches a stream of digital temperature samples and drives one active-low alarm line. Each sample is a 13-bit two's-complement value with a step of 0.0625 °C. Software sets a lower and an upper window bound, a critical trip point and a configuration word through a plain register port. The configuration word picks the alarm behaviour, the window enable, the critical-only setting and a hysteresis amount. A separate clear request lets software acknowledge an alarm when the current behaviour allows it.

There are three behaviours. In latched (interrupt) behaviour, a new crossing of a window bound pulls the line low. The line stays low until software clears it, and it can go low again only after a further new crossing. In level (comparator) behaviour, the line follows the window state, and software cannot clear it. In critical-only behaviour, the window is ignored and only the critical trip point counts. In every behaviour, a sample above the critical trip point pulls the line low, and the line is released only when the temperature falls back. A clear request does not release a critical alarm. A lock bit, once set, freezes the critical trip point until reset.

The line models an open-drain output: 0 means the line is driven low and 1 means it is released. The sensor conversion, the serial bus and any presence-detect storage belong to other blocks.

Top module: `therm_event_ctrl`

## Requirements
- R1: After reset, eventN is 1 (released). The registers read as follows: configuration 0x0000, lower bound 0x0000, upper bound 0x0550 (85 °C), critical point 0x05F0 (95 °C), temperature 0x0000.
- R2: Register addresses are 0 configuration, 1 lower bound, 2 upper bound, 3 critical point and 4 last temperature (read-only). A write to address 4 is ignored. Reads of addresses 1 to 4 return the 13-bit value sign-extended to 16 bits. The configuration reads back zero-extended.
- R3: Configuration bit 0 = 1 selects level behaviour, and bit 1 = 1 enables the window. With both set and bit 2 = 0, eventN goes to 0 in the cycle after a sample strictly above the upper bound or strictly below the lower bound. It returns to 1 after a sample back inside the bounds. All comparisons are signed.
- R4: In level behaviour, a clear request leaves eventN unchanged.
- R5: Bit 0 = 0 selects latched behaviour. With the window enabled, a new crossing (a sample that moves the temperature from inside to outside a bound) drives eventN to 0. It stays 0 after the temperature returns inside, until a clear request releases it in the following cycle.
- R6: In latched behaviour, after a clear, further samples that stay outside the same bound do not assert eventN again. It asserts again only on the next new crossing.
- R7: Configuration bit 2 = 1 selects critical-only behaviour. The window bounds then have no effect, and eventN is 0 only while the critical condition holds.
- R8: In any behaviour, with or without the window, a sample strictly above the critical point drives eventN to 0 in the next cycle. A clear request does not release it. It is released only by a sample at or below the critical point minus the hysteresis.
- R9: Configuration bits [4:3] select a hysteresis of 0, 24, 48 or 96 LSB (0, 1.5, 3 or 6 °C). The hysteresis applies only when an alarm condition ends. The upper condition ends at a sample at or below upper minus hysteresis. The lower condition ends at a sample at or above lower plus hysteresis. The critical condition ends at a sample at or below critical minus hysteresis.
- R10: Configuration bit 5 is a lock. Once it is written as 1, it reads as 1 until reset, and writes to the critical point are ignored.
- R11: The temperature register and the alarm conditions change only in cycles with tempValid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 13 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| tempValid | input | 1 | Temperature sample is valid this cycle |
| tempSample | input | 13 | Temperature sample, two's complement, 0.0625 °C per LSB |
| clrReq | input | 1 | Alarm clear request, one cycle |
| eventN | output | 1 | Alarm line: 0 driven low, 1 released |

## Verification
The bench targets the exact bound values: a sample equal to a bound, and samples one LSB past it, with hysteresis 0, 24 and 48. A design using the wrong inequality, or applying hysteresis on assertion as well as on release, releases or asserts one sample early. In latched behaviour, the bench clears while the temperature is still outside and then sends another outside sample. A design that treats "outside" as a crossing asserts again at once. The bench also sends clear requests during level and critical alarms, where a wrongly clearable design releases the line. It checks that critical-only behaviour ignores a sample above the upper bound. It checks that a locked critical point, or a read-only temperature register, does not take a write, that negative bounds compare as signed values, and that the temperature holds while tempValid is low.

// File: rtl/therm_pkg.sv
package therm_pkg;

  // register map
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_LOW  = 1;
  localparam int ADDR_HIGH = 2;
  localparam int ADDR_CRIT = 3;
  localparam int ADDR_TEMP = 4;

  // configuration word, bit 5 down to bit 0
  typedef struct packed {
    logic       lock;
    logic [1:0] hyst;
    logic       critOnly;
    logic       winEn;
    logic       compMode;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // strobes from control to datapath
  typedef struct packed {
    logic wrCfg;
    logic wrLow;
    logic wrHigh;
    logic wrCrit;
    logic loadTemp;
  } strobe_t;

  // alarm conditions
  typedef struct packed {
    logic above;
    logic below;
    logic crit;
  } flags_t;

endpackage

// File: rtl/therm_dp.sv
module therm_dp
  import therm_pkg::*;
#(
  parameter int TEMP_W = 13,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3,
  parameter int HYST_STEP = 24,
  parameter logic [TEMP_W-1:0] LOW_RST  = '0,
  parameter logic [TEMP_W-1:0] HIGH_RST = TEMP_W'(1360),
  parameter logic [TEMP_W-1:0] CRIT_RST = TEMP_W'(1520)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [TEMP_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [TEMP_W-1:0] tempIn,
  output cfg_t              cfgQ,
  output flags_t            flagsQ,
  output flags_t            flagsNext
);

  localparam int EXT_W = TEMP_W + 3;
  localparam int PAD_W = DATA_W - TEMP_W;

  logic [TEMP_W-1:0] lowQ, highQ, critLimQ, tempQ;
  cfg_t              cfgWr;

  // the lock bit stays set once written
  always_comb begin
    cfgWr      = cfg_t'(wrData[CFG_W-1:0]);
    cfgWr.lock = cfgWr.lock | cfgQ.lock;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ     <= '0;
      lowQ     <= LOW_RST;
      highQ    <= HIGH_RST;
      critLimQ <= CRIT_RST;
      tempQ    <= '0;
    end else begin
      if (stb.wrCfg)    cfgQ     <= cfgWr;
      if (stb.wrLow)    lowQ     <= wrData;
      if (stb.wrHigh)   highQ    <= wrData;
      if (stb.wrCrit)   critLimQ <= wrData;
      if (stb.loadTemp) tempQ    <= tempIn;
    end
  end

  // signed extension to the compare width
  function automatic logic signed [EXT_W-1:0] sx(input logic [TEMP_W-1:0] v);
    return $signed({{(EXT_W-TEMP_W){v[TEMP_W-1]}}, v});
  endfunction

  logic signed [EXT_W-1:0] tS, lowS, highS, critS, hVal;

  always_comb begin
    case (cfgQ.hyst)
      2'd0:    hVal = '0;
      2'd1:    hVal = EXT_W'(HYST_STEP);
      2'd2:    hVal = EXT_W'(HYST_STEP * 2);
      default: hVal = EXT_W'(HYST_STEP * 4);
    endcase
  end

  assign tS    = sx(tempIn);
  assign lowS  = sx(lowQ);
  assign highS = sx(highQ);
  assign critS = sx(critLimQ);

  // condition update, hysteresis applied on the release side only
  always_comb begin
    flagsNext = flagsQ;
    if (stb.loadTemp) begin
      flagsNext.above = flagsQ.above ? (tS > highS - hVal) : (tS > highS);
      flagsNext.below = flagsQ.below ? (tS < lowS + hVal)  : (tS < lowS);
      flagsNext.crit  = flagsQ.crit  ? (tS > critS - hVal) : (tS > critS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= flagsNext;
  end

  // read mux
  always_comb begin
    case (int'(rdAddr))
      ADDR_CFG:  rdData = DATA_W'(cfgQ);
      ADDR_LOW:  rdData = {{PAD_W{lowQ[TEMP_W-1]}}, lowQ};
      ADDR_HIGH: rdData = {{PAD_W{highQ[TEMP_W-1]}}, highQ};
      ADDR_CRIT: rdData = {{PAD_W{critLimQ[TEMP_W-1]}}, critLimQ};
      ADDR_TEMP: rdData = {{PAD_W{tempQ[TEMP_W-1]}}, tempQ};
      default:   rdData = '0;
    endcase
  end

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.lock |=> cfgQ.lock);

  // R10
  crit_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.lock |=> $stable(critLimQ));

  // R11
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadTemp |=> $stable(flagsQ) && $stable(tempQ));

endmodule

// File: rtl/therm_ctl.sv
module therm_ctl
  import therm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              tempValid,
  input  logic              clrReq,
  input  logic              lockQ,
  input  logic              compMode,
  input  logic              winEn,
  input  logic              critOnly,
  input  flags_t            flagsQ,
  input  flags_t            flagsNext,
  output strobe_t           stb,
  output logic              eventN
);

  // register write decode, critical point gated by the lock
  always_comb begin
    stb.wrCfg    = regWr && (regAddr == ADDR_W'(ADDR_CFG));
    stb.wrLow    = regWr && (regAddr == ADDR_W'(ADDR_LOW));
    stb.wrHigh   = regWr && (regAddr == ADDR_W'(ADDR_HIGH));
    stb.wrCrit   = regWr && (regAddr == ADDR_W'(ADDR_CRIT)) && !lockQ;
    stb.loadTemp = tempValid;
  end

  logic winLive, armed, crossing, latchQ, latchNext, winOut, evtNext;

  assign winLive  = winEn && !critOnly;
  assign armed    = winLive && !compMode;
  assign crossing = (flagsNext.above && !flagsQ.above) ||
                    (flagsNext.below && !flagsQ.below);

  // latched behaviour: a new crossing beats a clear in the same cycle
  always_comb begin
    if (!armed)        latchNext = 1'b0;
    else if (crossing) latchNext = 1'b1;
    else if (clrReq)   latchNext = 1'b0;
    else               latchNext = latchQ;
  end

  always_comb begin
    if (!winLive)     winOut = 1'b0;
    else if (compMode) winOut = flagsNext.above || flagsNext.below;
    else              winOut = latchNext;
    evtNext = flagsNext.crit || winOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ <= 1'b0;
      eventN <= 1'b1;
    end else begin
      latchQ <= latchNext;
      eventN <= !evtNext;
    end
  end

  // R8
  crit_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ.crit |-> !eventN);

  // R7
  crit_only_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(critOnly) && !flagsQ.crit |-> eventN);

  // R3
  level_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(compMode && winEn && !critOnly) && (flagsQ.above || flagsQ.below) |-> !eventN);

  // R10
  locked_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |-> !stb.wrCrit);

endmodule

// File: rtl/therm_event_ctrl.sv
module therm_event_ctrl
  import therm_pkg::*;
#(
  parameter int TEMP_W = 13,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [TEMP_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tempValid,
  input  logic [TEMP_W-1:0] tempSample,
  input  logic              clrReq,
  output logic              eventN
);

  strobe_t stb;
  cfg_t    cfgQ;
  flags_t  flagsQ, flagsNext;

  therm_ctl #(.ADDR_W(ADDR_W)) ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .tempValid (tempValid),
    .clrReq    (clrReq),
    .lockQ     (cfgQ.lock),
    .compMode  (cfgQ.compMode),
    .winEn     (cfgQ.winEn),
    .critOnly  (cfgQ.critOnly),
    .flagsQ    (flagsQ),
    .flagsNext (flagsNext),
    .stb       (stb),
    .eventN    (eventN)
  );

  therm_dp #(.TEMP_W(TEMP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (regWrData),
    .rdAddr    (regAddr),
    .rdData    (regRdData),
    .tempIn    (tempSample),
    .cfgQ      (cfgQ),
    .flagsQ    (flagsQ),
    .flagsNext (flagsNext)
  );

endmodule

// File: tb/therm_event_ctrl_tb_top.sv
module therm_event_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [12:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        tempValid = 1'b0;
  logic [12:0] tempSample = '0;
  logic        clrReq = 1'b0;
  logic        eventN;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // scoreboard queues for the alarm line
  int    dueQ[$];
  bit    expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  therm_event_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tempValid(tempValid),
    .tempSample(tempSample), .clrReq(clrReq), .eventN(eventN)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares the alarm line when an expectation falls due
  always @(negedge clk) begin
    while (dueQ.size() > 0 && dueQ[0] <= cyc) begin
      chk(eventN === expQ[0], tagQ[0], int'(eventN), int'(expQ[0]));
      void'(dueQ.pop_front());
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
    end
  end

  task automatic push(bit exp, string tag);
    dueQ.push_back(cyc + 1);
    expQ.push_back(exp);
    tagQ.push_back(tag);
  endtask

  task automatic sample(int t, bit exp, string tag);
    @(negedge clk);
    tempValid  = 1'b1;
    tempSample = 13'(t);
    push(exp, tag);
    @(negedge clk);
    tempValid = 1'b0;
  endtask

  task automatic clear(bit exp, string tag);
    @(negedge clk);
    clrReq = 1'b1;
    push(exp, tag);
    @(negedge clk);
    clrReq = 1'b0;
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    regWr     = 1'b1;
    regAddr   = 3'(addr);
    regWrData = 13'(data);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(int addr, int exp, string tag);
    @(negedge clk);
    regAddr = 3'(addr);
    #1;
    chk(regRdData === 16'(exp), tag, int'(regRdData), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lineNow(bit exp, string tag);
    @(negedge clk);
    chk(eventN === exp, tag, int'(eventN), int'(exp));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    lineNow(1'b1, "R1 line released");
    rd(0, 16'h0000, "R1 cfg");
    rd(1, 16'h0000, "R1 lower");
    rd(2, 16'h0550, "R1 upper");
    rd(3, 16'h05F0, "R1 crit");
    rd(4, 16'h0000, "R1 temp");

    // R2 programming and readback
    wr(2, 800);
    wr(3, 1600);
    wr(1, -160);
    rd(2, 16'h0320, "R2 upper");
    rd(1, 16'hFF60, "R2 lower sign extended");
    wr(4, 13'h0123);
    rd(4, 16'h0000, "R2 temp read-only");

    // R3 level behaviour, window on, no hysteresis
    wr(0, 6'h03);
    idle(2);
    sample(400, 1'b1, "R3 inside");
    sample(801, 1'b0, "R3 above upper");
    clear(1'b0, "R4 clear ignored in level");
    sample(800, 1'b1, "R3 back at bound");
    sample(-161, 1'b0, "R3 below negative lower");
    sample(-160, 1'b1, "R3 at lower bound");

    // R9 hysteresis 48
    wr(0, 6'h13);
    idle(2);
    sample(900, 1'b0, "R9 above");
    sample(760, 1'b0, "R9 inside band holds");
    sample(752, 1'b1, "R9 release at upper-h");
    sample(-200, 1'b0, "R9 below");
    sample(-120, 1'b0, "R9 lower band holds");
    sample(-112, 1'b1, "R9 release at lower+h");

    // R5 / R6 latched behaviour
    wr(0, 6'h02);
    idle(2);
    sample(900, 1'b0, "R5 crossing asserts");
    sample(400, 1'b0, "R5 stays after return");
    clear(1'b1, "R5 clear releases");
    sample(900, 1'b0, "R5 new crossing");
    clear(1'b1, "R6 clear while outside");
    sample(950, 1'b1, "R6 no rearm while outside");
    sample(400, 1'b1, "R6 return quiet");
    sample(900, 1'b0, "R6 rearmed crossing");
    clear(1'b1, "R6 final clear");

    // R7 critical-only
    wr(0, 6'h06);
    idle(2);
    lineNow(1'b1, "R7 window ignored");
    sample(1500, 1'b1, "R7 above upper only");
    sample(1601, 1'b0, "R7 critical trip");
    clear(1'b0, "R8 clear ignored on critical");
    sample(1600, 1'b1, "R7 release at crit");

    // R8 critical with window off, latched, hysteresis 24
    wr(0, 6'h08);
    idle(2);
    sample(1700, 1'b0, "R8 trip window off");
    clear(1'b0, "R8 clear no effect");
    sample(1590, 1'b0, "R8 hysteresis holds");
    sample(1576, 1'b1, "R8 release at crit-h");

    // R10 lock
    wr(3, 16'h0700);
    rd(3, 16'h0700, "R10 crit writable before lock");
    wr(0, 6'h20);
    wr(0, 6'h00);
    rd(0, 16'h0020, "R10 lock sticky");
    wr(3, 16'h0100);
    rd(3, 16'h0700, "R10 crit frozen");

    // R11 sample gating
    rd(4, 16'h0628, "R11 last sample");
    @(negedge clk);
    tempSample = 13'd0;
    idle(2);
    rd(4, 16'h0628, "R11 held without valid");
    lineNow(1'b1, "R11 line unchanged");

    idle(3);
    if (dueQ.size() != 0) chk(1'b0, "scoreboard drained", dueQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule